// File: doc/BRIEF.md
# Chained Limb Multiply-Add Unit

This block multiplies 64-bit unsigned words and adds a 64-bit addend. Each operation forms A*B + C at full 128-bit width. The low word is the result. The high word is not sent out as a result. It is kept as the carry word and used as the addend C of the following operation.

A start handshake sets up a job. It gives the scalar multiplier B, the initial carry word, the mode bit and a length field. Limbs (the A operands) are then offered one at a time on a separate valid/ready port, least significant limb first. For each limb the block returns one low word, tagged with the limb's index. After the last limb it raises a one-cycle completion pulse, and the final carry word sits on a held output as the overflow limb.

Scalar mode is a job of exactly one limb. Its high word goes only to the carry output. The multiply is registered and then delayed through a parameterised number of stages. Only one limb is in flight at a time, because each limb needs the carry of the one before it.

Top module: `limb_mac_chain`

## Requirements
- R1: For every accepted limb A, `res_data` equals (A*B + C) mod 2^64, where B is the job's multiplier and C is the current carry word.
- R2: The upper 64 bits of each product-sum become the addend for the next limb. The first limb uses the job's carry-in. After the last limb, `carry_out` equals the upper 64 bits of the last product-sum.
- R3: With all three operands equal to 2^64-1, the product-sum is 2^128-2^64. The result word is 0 and the carry word is 2^64-1, and no bit is lost.
- R4: In vector mode (`start_vec`=1), limbs are consumed in order. `res_index` runs 0,1,2,... and never exceeds the job length minus one. The same multiplier is used for every limb.
- R5: The job length is `start_len`+1 limbs, sampled only when the start is accepted. Changing `start_len`, `start_mul` or `start_carry` afterwards has no effect on the job. No limb beyond the length is accepted.
- R6: In scalar mode (`start_vec`=0), the job has exactly one limb whatever `start_len` holds. The upper word appears only on `carry_out`, never on `res_data`.
- R7: `done` is a single-cycle pulse in the cycle after the last `res_valid`, with `carry_out` already final. `carry_out` keeps its value until the next start is accepted.
- R8: `start_ready` is high only while idle. `limb_ready` is high only while the job waits for a limb and the multiplier holds nothing in flight. Results are never back to back.
- R9: `res_valid` rises exactly MUL_LAT cycles after the clock edge that accepts a limb.
- R10: After reset, `start_ready`=1, `limb_ready`=0, `res_valid`=0, `done`=0 and `carry_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Job request |
| start_ready | output | 1 | Job request accepted this cycle when high with start_valid |
| start_vec | input | 1 | 1 = vector job, 0 = single scalar operation |
| start_len | input | LEN_W | Limb count minus one (vector mode only) |
| start_mul | input | 64 | Scalar multiplier B |
| start_carry | input | 64 | Initial addend C |
| limb_valid | input | 1 | Limb offered |
| limb_ready | output | 1 | Limb accepted this cycle when high with limb_valid |
| limb_data | input | 64 | Limb operand A |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 64 | Low word of the product-sum |
| res_index | output | LEN_W | Index of the limb this result belongs to |
| done | output | 1 | One-cycle job completion pulse |
| carry_out | output | 64 | Running carry word; final overflow limb after done |

## Verification
A corrupted carry register shows up at the next limb's `res_data`, MUL_LAT cycles after that limb is accepted. It shows on `carry_out` at the latest with `done`. A wrong limb counter shows at once on `res_index`, or as a missing or extra `limb_ready` after the last result. A latched length that was resampled shows the same way. A stage-valid bit that is stuck or lost changes the distance between limb acceptance and `res_valid`, so the first limb of any job exposes it.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

  localparam int WORD_W = 64;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t hi;
    word_t lo;
  } dword_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_CALC = 2'd2
  } seq_state_t;

  // Full-width product-sum; (2^W-1)^2 + (2^W-1) fits in 2W bits.
  function automatic dword_t fma_word(input word_t a, input word_t b, input word_t c);
    logic [2*WORD_W-1:0] p;
    p = {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b} + {{WORD_W{1'b0}}, c};
    return dword_t'(p);
  endfunction

endpackage

// File: rtl/lmac_unit.sv
module lmac_unit
  import lmac_pkg::*;
#(
  parameter int LAT = 2  // must be at least 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  word_t in_a,
  input  word_t in_b,
  input  word_t in_c,
  output logic  out_valid,
  output word_t out_lo,
  output word_t out_hi
);

  logic [LAT-1:0] vld_q;
  dword_t         sum_q [LAT];
  logic           pipe_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= in_valid;
      for (int s = 1; s < LAT; s++) vld_q[s] <= vld_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) sum_q[0] <= fma_word(in_a, in_b, in_c);
    for (int s = 1; s < LAT; s++) begin
      if (vld_q[s-1]) sum_q[s] <= sum_q[s-1];
    end
  end

  assign pipe_busy = |vld_q;
  assign out_valid = vld_q[LAT-1];
  assign out_lo    = sum_q[LAT-1].lo;
  assign out_hi    = sum_q[LAT-1].hi;

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !pipe_busy); // R8

endmodule

// File: rtl/lmac_seq.sv
module lmac_seq
  import lmac_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MUL_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic             start_vec,
  input  logic [LEN_W-1:0] start_len,
  input  word_t            start_mul,
  input  word_t            start_carry,
  input  logic             limb_valid,
  output logic             limb_ready,
  input  word_t            limb_data,
  output logic             issue_valid,
  output word_t            issue_a,
  output word_t            issue_b,
  output word_t            issue_c,
  input  logic             unit_valid,
  input  word_t            unit_lo,
  input  word_t            unit_hi,
  output logic             res_valid,
  output word_t            res_data,
  output logic [LEN_W-1:0] res_index,
  output logic             done,
  output word_t            carry_out
);

  localparam int LAT_W = $clog2(MUL_LAT + 1) + 1;

  seq_state_t       state_q;
  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] last_q;
  word_t            mul_q;
  word_t            carry_q;
  logic             done_q;
  logic [LAT_W-1:0] lat_cnt_q;

  logic start_fire;
  logic limb_fire;
  logic is_last;
  logic chain_step;

  assign start_ready = (state_q == SQ_IDLE);
  assign limb_ready  = (state_q == SQ_WAIT);
  assign start_fire  = start_valid && start_ready;
  assign limb_fire   = limb_valid && limb_ready;
  assign is_last     = (idx_q == last_q);
  assign chain_step  = unit_valid && (state_q == SQ_CALC);

  assign issue_valid = limb_fire;
  assign issue_a     = limb_data;
  assign issue_b     = mul_q;
  assign issue_c     = carry_q;

  assign res_valid   = chain_step;
  assign res_data    = unit_lo;
  assign res_index   = idx_q;
  assign done        = done_q;
  assign carry_out   = carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      mul_q   <= '0;
      carry_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= chain_step && is_last;
      unique case (state_q)
        SQ_IDLE: begin
          if (start_fire) begin
            mul_q   <= start_mul;
            carry_q <= start_carry;
            last_q  <= start_vec ? start_len : '0;
            idx_q   <= '0;
            state_q <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (limb_fire) state_q <= SQ_CALC;
        end
        SQ_CALC: begin
          if (chain_step) begin
            carry_q <= unit_hi;
            if (is_last) begin
              state_q <= SQ_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= SQ_WAIT;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // Cycles since the last limb was issued, for the latency check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt_q <= '0;
    end else if (limb_fire) begin
      lat_cnt_q <= LAT_W'(1);
    end else if (state_q == SQ_CALC && !unit_valid) begin
      lat_cnt_q <= lat_cnt_q + 1'b1;
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (lat_cnt_q == LAT_W'(MUL_LAT))); // R9
  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_index <= last_q)); // R4
  AST_RESULT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid)); // R7
  AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(start_fire) && !$past(res_valid)) |-> $stable(carry_out)); // R7

endmodule

// File: rtl/limb_mac_chain.sv
module limb_mac_chain
  import lmac_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MUL_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic             start_vec,
  input  logic [LEN_W-1:0] start_len,
  input  logic [63:0]      start_mul,
  input  logic [63:0]      start_carry,
  input  logic             limb_valid,
  output logic             limb_ready,
  input  logic [63:0]      limb_data,
  output logic             res_valid,
  output logic [63:0]      res_data,
  output logic [LEN_W-1:0] res_index,
  output logic             done,
  output logic [63:0]      carry_out
);

  logic  issue_valid;
  word_t issue_a;
  word_t issue_b;
  word_t issue_c;
  logic  unit_valid;
  word_t unit_lo;
  word_t unit_hi;

  lmac_seq #(
    .LEN_W   (LEN_W),
    .MUL_LAT (MUL_LAT)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .start_vec   (start_vec),
    .start_len   (start_len),
    .start_mul   (start_mul),
    .start_carry (start_carry),
    .limb_valid  (limb_valid),
    .limb_ready  (limb_ready),
    .limb_data   (limb_data),
    .issue_valid (issue_valid),
    .issue_a     (issue_a),
    .issue_b     (issue_b),
    .issue_c     (issue_c),
    .unit_valid  (unit_valid),
    .unit_lo     (unit_lo),
    .unit_hi     (unit_hi),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_index   (res_index),
    .done        (done),
    .carry_out   (carry_out)
  );

  lmac_unit #(
    .LAT (MUL_LAT)
  ) unit_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (issue_valid),
    .in_a      (issue_a),
    .in_b      (issue_b),
    .in_c      (issue_c),
    .out_valid (unit_valid),
    .out_lo    (unit_lo),
    .out_hi    (unit_hi)
  );

endmodule

// File: tb/limb_mac_chain_tb.sv
`timescale 1ns/1ps
module limb_mac_chain_tb_top;

  localparam int LEN_W   = 4;
  localparam int MUL_LAT = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_valid = 1'b0;
  logic             start_ready;
  logic             start_vec = 1'b0;
  logic [LEN_W-1:0] start_len = '0;
  logic [63:0]      start_mul = '0;
  logic [63:0]      start_carry = '0;
  logic             limb_valid = 1'b0;
  logic             limb_ready;
  logic [63:0]      limb_data = '0;
  logic             res_valid;
  logic [63:0]      res_data;
  logic [LEN_W-1:0] res_index;
  logic             done;
  logic [63:0]      carry_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] lv   [16];
  logic [63:0] seen [16];

  always #4 clk = ~clk;

  limb_mac_chain #(.LEN_W(LEN_W), .MUL_LAT(MUL_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready), .start_vec(start_vec),
    .start_len(start_len), .start_mul(start_mul), .start_carry(start_carry),
    .limb_valid(limb_valid), .limb_ready(limb_ready), .limb_data(limb_data),
    .res_valid(res_valid), .res_data(res_data), .res_index(res_index),
    .done(done), .carry_out(carry_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference product-sum from 32-bit partial products.
  function automatic void ref_mac(input logic [63:0] a, input logic [63:0] b,
                                  input logic [63:0] c,
                                  output logic [63:0] lo, output logic [63:0] hi);
    logic [63:0]  ll, lh, hl, hh;
    logic [127:0] acc;
    ll  = 64'(a[31:0])  * 64'(b[31:0]);
    lh  = 64'(a[31:0])  * 64'(b[63:32]);
    hl  = 64'(a[63:32]) * 64'(b[31:0]);
    hh  = 64'(a[63:32]) * 64'(b[63:32]);
    acc = {64'b0, ll} + ({64'b0, lh} << 32) + ({64'b0, hl} << 32)
        + {hh, 64'b0} + {64'b0, c};
    lo  = acc[63:0];
    hi  = acc[127:64];
  endfunction

  function automatic logic [63:0] xs(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic run_chain(input logic vec, input logic [LEN_W-1:0] lenf,
                           input logic [63:0] mul, input logic [63:0] cin,
                           input int nlimbs, input logic [LEN_W-1:0] len_after);
    logic [63:0] c_exp, lo_e, hi_e;
    int cyc;
    c_exp = cin;
    @(negedge clk);
    start_valid = 1'b1; start_vec = vec; start_len = lenf;
    start_mul = mul; start_carry = cin;
    while (!start_ready) @(negedge clk);
    @(negedge clk);
    start_valid = 1'b0; start_len = len_after;
    start_mul = '1; start_carry = '1;           // R5: must not affect the job
    chk("R8 start_ready low during job", 64'(start_ready), 64'd0);
    for (int i = 0; i < nlimbs; i++) begin
      limb_valid = 1'b1; limb_data = lv[i];
      while (!limb_ready) @(negedge clk);
      @(negedge clk);
      limb_valid = 1'b0; limb_data = '0;
      cyc = 1;
      chk("R8 limb_ready low while busy", 64'(limb_ready), 64'd0);
      while (!res_valid && cyc < 50) begin
        @(negedge clk);
        cyc++;
      end
      chk("R9 result latency", 64'(cyc), 64'(MUL_LAT));
      ref_mac(lv[i], mul, c_exp, lo_e, hi_e);
      seen[i] = res_data;
      chk("R1 low word", res_data, lo_e);
      chk("R4 limb index", 64'(res_index), 64'(i));
      c_exp = hi_e;
      @(negedge clk);
      if (i == nlimbs - 1) begin
        chk("R7 done after last result", 64'(done), 64'd1);
        chk("R2 final carry word", carry_out, c_exp);
      end else begin
        chk("R7 no done mid-job", 64'(done), 64'd0);
        chk("R4 next limb requested", 64'(limb_ready), 64'd1);
      end
    end
    limb_valid = 1'b1; limb_data = 64'hDEAD;  // extra limb must be refused
    @(negedge clk);
    chk("R7 done is one cycle", 64'(done), 64'd0);
    chk("R7 carry held", carry_out, c_exp);
    chk("R5 no limb past length", 64'(limb_ready), 64'd0);
    chk("R5 no result past length", 64'(res_valid), 64'd0);
    chk("R8 start_ready back when idle", 64'(start_ready), 64'd1);
    limb_valid = 1'b0; limb_data = '0;
  endtask

  task automatic t_reset();
    chk("R10 start_ready", 64'(start_ready), 64'd1);
    chk("R10 limb_ready", 64'(limb_ready), 64'd0);
    chk("R10 res_valid", 64'(res_valid), 64'd0);
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 carry_out", carry_out, 64'd0);
  endtask

  task automatic t_example();
    lv[0] = 64'h1357_0000_9BDF_0000;
    lv[1] = 64'h9ABC_0000_DEF0_0000;
    lv[2] = 64'h1234_0000_5678_0000;
    run_chain(1'b1, 4'd2, 64'h1_0001, 64'hFEDC, 3, 4'd2);
    chk("R2 example limb0", seen[0], 64'h1357_9BDF_9BDF_FEDC);
    chk("R2 example limb1", seen[1], 64'h9ABC_DEF0_DEF0_1357);
    chk("R2 example limb2", seen[2], 64'h1234_5678_5678_9ABC);
    chk("R2 example carry", carry_out, 64'h1234);
  endtask

  task automatic t_all_ones_scalar();
    lv[0] = '1;
    lv[1] = '1;
    run_chain(1'b0, 4'd5, '1, '1, 1, 4'd5);   // R6: length field ignored
    chk("R3 low word zero", seen[0], 64'd0);
    chk("R3 R6 upper word on carry only", carry_out, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_long_vector();
    logic [63:0] x;
    x = 64'h0123_4567_89AB_CDEF;
    for (int i = 0; i < 16; i++) begin
      x = xs(x);
      lv[i] = x;
    end
    run_chain(1'b1, 4'd15, 64'hF00D_BEEF_CAFE_1234, 64'h5555_AAAA_0F0F_F0F0, 16, 4'd0);
  endtask

  task automatic t_len_sampled();
    lv[0] = 64'hFFFF_FFFF_0000_0001;
    lv[1] = 64'h8000_0000_0000_0000;
    lv[2] = 64'h0000_0000_0000_0003;
    run_chain(1'b1, 4'd2, 64'hFFFF_FFFF_FFFF_FFFE, 64'd7, 3, 4'd15);  // R5
  endtask

  task automatic t_zero_mul();
    lv[0] = 64'h1111;
    lv[1] = 64'h2222;
    run_chain(1'b1, 4'd1, 64'd0, 64'hABCD, 2, 4'd1);
    chk("R1 zero multiplier passes addend", seen[0], 64'hABCD);
    chk("R2 zero multiplier empties carry", seen[1], 64'd0);
  endtask

  task automatic t_idle_hold();
    logic [63:0] held;
    held = carry_out;
    limb_valid = 1'b1; limb_data = 64'h77;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 limb refused when idle", 64'(limb_ready), 64'd0);
      chk("R8 no result when idle", 64'(res_valid), 64'd0);
      chk("R7 carry held when idle", carry_out, held);
    end
    limb_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_example();
    t_all_ones_scalar();
    t_long_vector();
    t_len_sampled();
    t_zero_mul();
    t_idle_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule